// File: doc/BRIEF.md
# Indexed Indirect Operand Address Generator

This block turns the address part of a 36-bit single-address instruction into an 18-bit operand address or an immediate operand. It reads one index register through a read port. A zero designator means the instruction uses no index. When an index is used, the block adds the register's low half to the zero-extended 16-bit offset. It can then write the register back with its low half advanced by its high half, using ones complement arithmetic.

When the indirect flag is set, the block fetches the word at the formed address over a simple request/acknowledge read port. It puts that word's low 22 bits in place of the instruction's, then forms the address again, with indexing and post-increment applied at every step. This goes on until a word with the indirect flag clear is reached, or until a chain-length bound is exceeded. A final address below 128 is flagged as a hit in the local register window. Two minor codes turn the final value into an 18-bit immediate, either zero-extended or sign-extended to 36 bits.

Top module: `ind_addr_gen`

## Requirements
- R1: The instruction's index designator is bits 21:18, increment flag bit 17, indirect flag bit 16 and offset bits 15:0. A designator of 0 makes the address the offset zero-extended to 18 bits, and no index write-back occurs.
- R2: With a non-zero designator, the address is the zero-extended offset plus bits 17:0 (modifier half) of the selected index register, modulo 2^18.
- R3: With the increment flag set and a non-zero designator, the block asserts `xwb_en` for the selected register with bits 35:18 (increment half) unchanged. Bits 17:0 are written as the ones complement sum of modifier and increment, using end-around carry. The address of that step uses the modifier from before the increment.
- R4: With the indirect flag set, the block reads the word at the formed address. Bits 21:0 of that word replace the current field, and address formation repeats until the indirect flag is clear. `mem_addr` stays stable while a request waits for `mem_ack`.
- R5: Each step of an indirect chain that has the increment flag and a non-zero designator writes its index register back. A later step that names the same register sees the updated value.
- R6: For a non-immediate result, `reg_win` is 1 exactly when the final address is below 128.
- R7: When minor code bits 29:26 equal 14, the result is an 18-bit immediate, zero-extended, and `imm` is 1. With a zero final designator the immediate is bits 17:0 of the final field; otherwise it is the offset-plus-modifier sum.
- R8: When minor code bits 29:26 equal 15, the 18-bit immediate of R7 is sign-extended from its bit 17 to 36 bits.
- R9: When a step needs a fetch after MAX_IND fetches have already been made, the block ends with `fault` set and `result` equal to 0. It makes no further fetch and no write-back in that step.
- R10: After reset, `busy`, `done`, `mem_req` and `xwb_en` are 0. `done` is a single-cycle pulse, and `start` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin forming an address for `instr` |
| instr | input | 36 | Instruction word |
| busy | output | 1 | Operation in progress |
| idx_sel | output | 4 | Index register read select |
| idx_data | input | 36 | Selected index register contents (combinational) |
| xwb_en | output | 1 | Index write-back strobe |
| xwb_sel | output | 4 | Index register to write |
| xwb_data | output | 36 | Write-back value |
| mem_req | output | 1 | Indirect word read request |
| mem_addr | output | 18 | Indirect word address |
| mem_ack | input | 1 | Read data valid |
| mem_data | input | 36 | Indirect word |
| done | output | 1 | Result valid pulse |
| result | output | 36 | Final address (zero-extended) or immediate |
| reg_win | output | 1 | Final address falls in the register window |
| imm | output | 1 | Result is an immediate |
| fault | output | 1 | Indirect chain exceeded its bound |

## Verification
A direct sweep covers every designator with and without increment and with plain, zero-extend and sign-extend codes. It uses offsets at 0, 127, 128 and the top of the range, so it separates unindexed from indexed sums, window hits from misses and the two extension rules. Index registers are seeded with negative increments and with pairs that cancel to negative zero, which exercises end-around carry. A second sweep starts indirect chains from every word of a small memory, so chains of differing length both end normally and run past the bound. In that sweep a spurious `start` pulse is given mid-chain to show it is ignored.

// File: rtl/ind_addr_gen.sv
module ind_addr_gen #(
  parameter int WW      = 36,
  parameter int XW      = 4,
  parameter int REG_WIN = 128,
  parameter int MAX_IND = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] instr,
  output logic          busy,
  output logic [XW-1:0] idx_sel,
  input  logic [WW-1:0] idx_data,
  output logic          xwb_en,
  output logic [XW-1:0] xwb_sel,
  output logic [WW-1:0] xwb_data,
  output logic          mem_req,
  output logic [WW/2-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [WW-1:0] mem_data,
  output logic          done,
  output logic [WW-1:0] result,
  output logic          reg_win,
  output logic          imm,
  output logic          fault
);
  localparam int HW   = WW / 2;
  localparam int OFFW = 16;
  localparam int FLDW = OFFW + 2 + XW;
  localparam int CW   = $clog2(MAX_IND + 1);
  localparam int JLO  = FLDW + 4;

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_FETCH} state_t;

  state_t          state;
  logic [FLDW-1:0] fld;
  logic [3:0]      jcode;
  logic [CW-1:0]   hops;
  logic [HW-1:0]   addr_q;
  logic            done_q, rw_q, imm_q, flt_q;
  logic [WW-1:0]   res_q;

  logic [XW-1:0]   fx;
  logic            fh, fi, use_x, over, is_imm, calc;
  logic [OFFW-1:0] fu;
  logic [HW-1:0]   xm, xi, sum, inc, imm_val;
  logic [HW:0]     inc_raw;
  logic [WW-1:0]   imm_ext;

  assign fx      = fld[FLDW-1 -: XW];
  assign fh      = fld[OFFW+1];
  assign fi      = fld[OFFW];
  assign fu      = fld[OFFW-1:0];
  assign use_x   = fx != '0;
  assign xm      = idx_data[HW-1:0];
  assign xi      = idx_data[WW-1:HW];
  assign sum     = {{(HW-OFFW){1'b0}}, fu} + (use_x ? xm : '0);
  assign inc_raw = {1'b0, xm} + {1'b0, xi};
  assign inc     = inc_raw[HW-1:0] + {{(HW-1){1'b0}}, inc_raw[HW]};
  assign is_imm  = jcode[3:1] == 3'b111;
  assign imm_val = use_x ? sum : fld[HW-1:0];
  assign imm_ext = jcode[0] ? {{HW{imm_val[HW-1]}}, imm_val} : {{HW{1'b0}}, imm_val};
  assign calc    = state == S_CALC;
  assign over    = fi && (hops == CW'(MAX_IND));

  assign busy     = state != S_IDLE;
  assign idx_sel  = fx;
  assign xwb_sel  = fx;
  assign xwb_en   = calc && fh && use_x && !over;
  assign xwb_data = {xi, inc};
  assign mem_req  = state == S_FETCH;
  assign mem_addr = addr_q;
  assign done     = done_q;
  assign result   = res_q;
  assign reg_win  = rw_q;
  assign imm      = imm_q;
  assign fault    = flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      fld    <= '0;
      jcode  <= '0;
      hops   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      rw_q   <= 1'b0;
      imm_q  <= 1'b0;
      flt_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fld   <= instr[FLDW-1:0];
          jcode <= instr[JLO +: 4];
          hops  <= '0;
          state <= S_CALC;
        end
        S_CALC: begin
          if (over) begin
            res_q  <= '0;
            rw_q   <= 1'b0;
            imm_q  <= 1'b0;
            flt_q  <= 1'b1;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (fi) begin
            addr_q <= sum;
            state  <= S_FETCH;
          end else begin
            res_q  <= is_imm ? imm_ext : {{(WW-HW){1'b0}}, sum};
            rw_q   <= !is_imm && (sum < HW'(REG_WIN));
            imm_q  <= is_imm;
            flt_q  <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        S_FETCH: if (mem_ack) begin
          fld   <= mem_data[FLDW-1:0];
          hops  <= hops + 1'b1;
          state <= S_CALC;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ind_addr_gen_chk.sv
module ind_addr_gen_chk #(
  parameter int WW      = 36,
  parameter int XW      = 4,
  parameter int REG_WIN = 128,
  parameter int MAX_IND = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic [WW-1:0]   idx_data,
  input logic            xwb_en,
  input logic [XW-1:0]   xwb_sel,
  input logic [WW-1:0]   xwb_data,
  input logic            mem_req,
  input logic [WW/2-1:0] mem_addr,
  input logic            mem_ack,
  input logic            done,
  input logic [WW-1:0]   result,
  input logic            reg_win,
  input logic            imm,
  input logic            fault
);
  localparam int HW = WW / 2;
  int unsigned acks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acks <= 0;
    else if (start && !busy) acks <= 0;
    else if (mem_req && mem_ack) acks <= acks + 1;
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R3
  wb_inc_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xwb_en |-> xwb_data[WW-1:HW] == idx_data[WW-1:HW]);
  // R1
  wb_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) xwb_en |-> xwb_sel != '0);
  // R6
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && reg_win |-> result < WW'(REG_WIN) && !imm && !fault);
  // R9
  fault_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> acks == MAX_IND && result == '0);
  // R9
  hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> acks <= MAX_IND);
endmodule

bind ind_addr_gen ind_addr_gen_chk #(.WW(WW), .XW(XW), .REG_WIN(REG_WIN), .MAX_IND(MAX_IND)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .idx_data(idx_data),
  .xwb_en(xwb_en), .xwb_sel(xwb_sel), .xwb_data(xwb_data), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .done(done), .result(result),
  .reg_win(reg_win), .imm(imm), .fault(fault)
);

// File: tb/ind_addr_gen_bench.sv
module ind_addr_gen_bench;
  localparam int MAXI = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [35:0] instr = '0;
  logic        busy, xwb_en, mem_req, done, reg_win, imm, fault;
  logic [3:0]  idx_sel, xwb_sel;
  logic [35:0] idx_data, xwb_data, mem_data, result;
  logic [17:0] mem_addr;
  logic        mem_ack;

  logic [35:0] xr [16];
  logic [35:0] exp_xr [16];
  logic [35:0] mem [64];

  int n_chk = 0, n_bad = 0, cycles = 0;

  always #2 clk = ~clk;

  ind_addr_gen #(.MAX_IND(MAXI)) u_ind_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .busy(busy),
    .idx_sel(idx_sel), .idx_data(idx_data), .xwb_en(xwb_en), .xwb_sel(xwb_sel),
    .xwb_data(xwb_data), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_data(mem_data), .done(done), .result(result), .reg_win(reg_win),
    .imm(imm), .fault(fault)
  );

  function automatic logic [35:0] seed_reg(int k);
    logic [17:0] hi, lo;
    hi = 18'((k * 2731) & 32'h3FFFF);
    lo = 18'((k * 40961 + 100) & 32'h3FFFF);
    if (k == 3) begin hi = 18'h3FFFE; lo = 18'd5; end
    if (k == 5) begin hi = 18'd5; lo = 18'h3FFFA; end
    if (k == 6) begin hi = 18'd1; lo = 18'h3FFFF; end
    if (k == 9) begin hi = 18'h3FF00; lo = 18'd20; end
    return {hi, lo};
  endfunction

  assign idx_data = xr[idx_sel];
  assign mem_data = mem[mem_addr[5:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) xr[k] <= seed_reg(k);
      mem_ack <= 1'b0;
    end else begin
      if (xwb_en) xr[xwb_sel] <= xwb_data;
      mem_ack <= mem_req && !mem_ack;
    end
  end

  bit wd_hit = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !wd_hit) begin
      wd_hit = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic predict(input logic [35:0] ins, output logic [35:0] er, output logic erw,
                         output logic eimm, output logic eflt, output int nfetch);
    logic [21:0] f;
    logic [3:0] j;
    int unsigned s, x, h, i, u, xm, xi;
    f = ins[21:0]; j = ins[29:26]; nfetch = 0;
    er = '0; erw = 0; eimm = 0; eflt = 0;
    for (int step = 0; step < 64; step++) begin
      x = f[21:18]; h = f[17]; i = f[16]; u = f[15:0];
      xm = exp_xr[x][17:0]; xi = exp_xr[x][35:18];
      s = (x != 0) ? ((u + xm) % 32'h40000) : u;
      if (i != 0 && nfetch == MAXI) begin eflt = 1; break; end
      if (h != 0 && x != 0) begin
        int unsigned t;
        t = xm + xi;
        if (t > 32'h3FFFF) t = t - 32'h40000 + 1;
        exp_xr[x][17:0] = 18'(t);
      end
      if (i != 0) begin
        f = mem[s % 64][21:0];
        nfetch++;
      end else begin
        if (j == 4'd14 || j == 4'd15) begin
          int unsigned v;
          v = (x != 0) ? s : f[17:0];
          eimm = 1;
          er = {18'd0, 18'(v)};
          if (j == 4'd15 && v[17]) er[35:18] = '1;
        end else begin
          er = {18'd0, 18'(s)};
          erw = s < 128;
        end
        break;
      end
    end
  endtask

  task automatic run_op(input logic [35:0] ins, input bit poke);
    logic [35:0] er; logic erw, eimm, eflt; int nf; int w;
    string rq;
    predict(ins, er, erw, eimm, eflt, nf);
    @(negedge clk); instr = ins; start = 1;
    @(negedge clk); start = 0;
    if (poke && busy) begin instr = ~ins; start = 1; @(negedge clk); start = 0; end
    w = 0;
    while (!done && w < 200) begin @(negedge clk); w++; end
    if (eflt) rq = "R9";
    else if (nf > 0) rq = "R4";
    else if (ins[29:26] == 4'd14) rq = "R7";
    else if (ins[29:26] == 4'd15) rq = "R8";
    else if (ins[21:18] == 0) rq = "R1";
    else rq = "R2";
    chk({rq, " done"}, 36'(done), 36'd1);
    chk({rq, " result"}, result, er);
    chk("R9 fault", 36'(fault), 36'(eflt));
    chk("R6 reg_win", 36'(reg_win), 36'(erw));
    chk("R7 imm flag", 36'(imm), 36'(eimm));
    @(negedge clk);
    chk("R10 done pulse", 36'(done), 36'd0);
    for (int k = 1; k < 16; k++)
      if (xr[k] !== exp_xr[k]) begin
        chk(nf > 0 ? "R5 index regs" : "R3 index regs", xr[k], exp_xr[k]);
        exp_xr[k] = xr[k];
      end
    n_chk++;
  endtask

  initial begin
    logic [15:0] offs [6];
    logic [3:0] js [3];
    offs[0] = 16'd0; offs[1] = 16'd1; offs[2] = 16'd127;
    offs[3] = 16'd128; offs[4] = 16'hFFFF; offs[5] = 16'h1234;
    js[0] = 4'd0; js[1] = 4'd14; js[2] = 4'd15;
    for (int k = 0; k < 16; k++) exp_xr[k] = seed_reg(k);
    for (int a = 0; a < 64; a++) begin
      logic [35:0] wv;
      wv = 36'h5A0000000;
      wv[21:18] = 4'(a % 4 == 0 ? 0 : (a % 7) + 1);
      wv[17] = (a % 3) == 0;
      wv[16] = (a % 5) != 0;
      wv[15:0] = 16'((a * 7 + 3) & 16'hFFFF);
      mem[a] = wv;
    end
    repeat (3) @(negedge clk);
    chk("R10 reset busy", 36'(busy), 36'd0);
    chk("R10 reset done", 36'(done), 36'd0);
    chk("R10 reset mem_req", 36'(mem_req), 36'd0);
    chk("R10 reset xwb_en", 36'(xwb_en), 36'd0);
    rst_n = 1;
    @(negedge clk);
    for (int x = 0; x < 16; x++)
      for (int h = 0; h < 2; h++)
        for (int o = 0; o < 6; o++)
          for (int jj = 0; jj < 3; jj++) begin
            logic [35:0] ins;
            ins = '0;
            ins[35:30] = 6'o12;
            ins[29:26] = js[jj];
            ins[25:22] = 4'(x ^ 4'hA);
            ins[21:18] = 4'(x);
            ins[17] = 1'(h);
            ins[15:0] = offs[o];
            run_op(ins, 0);
          end
    for (int a = 0; a < 64; a++)
      for (int xs = 0; xs < 3; xs++)
        for (int h = 0; h < 2; h++)
          for (int jj = 0; jj < 3; jj += 2) begin
            logic [35:0] ins;
            ins = '0;
            ins[29:26] = js[jj];
            ins[21:18] = xs == 0 ? 4'd0 : (xs == 1 ? 4'd2 : 4'd7);
            ins[17] = 1'(h);
            ins[16] = 1'b1;
            ins[15:0] = 16'(a);
            run_op(ins, 1);
          end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule